// File: doc/BRIEF.md
# Mealy Machine Checking-Sequence Tester

This block confirms that a one-bit Mealy machine under test behaves according to a fixed five-state table. After a start request it drives a precomputed checking sequence onto the machine's input, one bit per clock. In the same cycle it compares the machine's combinational response with the bit that a lockstep reference copy of the table predicts. The first mismatch is latched together with its step index. If the whole sequence completes with no mismatch, a pass verdict is reported.

The 76-step sequence has three parts. It opens with four zeros that force any correct machine into state A; responses during this prefix are masked. It then applies the distinguishing input pattern 1,1,0 from every state in turn, with single transfer inputs between them. It ends by exercising all ten table transitions, each followed by the distinguishing pattern. The sequence is stored as a short list of segment kinds and is expanded on the fly. The check is only meaningful for a machine with at most five states.

The reference table uses the notation "state, input -> next state / output":
- A: 0 -> A/1, 1 -> C/1
- B: 0 -> C/0, 1 -> A/1
- C: 0 -> D/0, 1 -> E/0
- D: 0 -> A/1, 1 -> B/1
- E: 0 -> B/0, 1 -> B/0

Top module: `mealy_check_seq`

## Requirements
- R1: After reset, busy_o, pass_o, fail_o and stim_o are 0 and fail_step_o is 0.
- R2: A start_i sampled high while idle raises busy_o on the next cycle. busy_o then stays high for exactly 76 cycles, and stim_o presents step k of the sequence in the k-th busy cycle (k from 0). While idle, stim_o is 0.
- R3: Steps 0 to 3 drive 0, and a response mismatch in those steps never sets fail_o, whatever the starting state of the machine.
- R4: Steps 4 to 20 drive 110,110,110,1,110,1,110, which visits the states in the order A, B, D, C, E. A correct machine answers 100,110,111,1,000,0,011.
- R5: Steps 21 to 75 drive 0,110,0,110,0,110,1,110,1,110,110,1,110,110,0,110,110,1,110,011,0,110,011,1,110. This covers every one of the ten table transitions, each followed by 110.
- R6: From step 4 on, the expected response of each step is the table output for the current reference state and the applied bit. The reference state is A at step 4 and then follows the table's next state.
- R7: On the first mismatch of a run, fail_o rises on the next cycle and fail_step_o holds that step index (0-based). Later mismatches in the same run change neither.
- R8: When busy_o falls, pass_o is 1 exactly when no mismatch occurred in the run. pass_o and fail_o are never both 1, and the verdict holds until the next accepted start.
- R9: start_i while busy_o is 1 is ignored: the sequence continues unchanged and the verdict is not cleared.
- R10: An accepted start clears pass_o, fail_o and fail_step_o, starting from the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| resp_i | input | 1 | Combinational response of the machine under test |
| stim_o | output | 1 | Input bit driven into the machine under test |
| busy_o | output | 1 | High while the sequence is running |
| pass_o | output | 1 | Run finished with no mismatch |
| fail_o | output | 1 | A mismatch was seen in the current or last run |
| fail_step_o | output | 7 | Step index of the first mismatch |

## Verification
The bench runs a fault-free machine from each of the five starting states. A tester that checked responses during the prefix would then fail some of these runs. A further run inverts every prefix response on purpose, which catches a mask that closes one step too early. Machines with a wrong output bit or a wrong next state must fail at the exact step that an independent model predicts. A tester whose reference drifted, or whose first-mismatch latch was overwritten, would report a different index. A start pulse in the middle of a run must leave the stream and the verdict untouched, while an accepted start must clear a stale verdict.

// File: rtl/chkseq_pkg.sv
package chkseq_pkg;
  localparam int SEQ_LEN = 76;
  localparam int SEG_CNT = 33;
  localparam int STEP_W  = $clog2(SEQ_LEN);
  localparam int SEG_W   = $clog2(SEG_CNT);
  localparam int OFF_W   = 2;

  typedef enum logic [2:0] {ST_A, ST_B, ST_C, ST_D, ST_E} st_e;
  // segment kinds: sync prefix, distinguishing 110, single 0, single 1, D-to-E transfer 011
  typedef enum logic [2:0] {SG_SYNC, SG_DIST, SG_ZERO, SG_ONE, SG_D2E} seg_e;

  function automatic st_e tbl_next(st_e s, logic i);
    case (s)
      ST_A:    return i ? ST_C : ST_A;
      ST_B:    return i ? ST_A : ST_C;
      ST_C:    return i ? ST_E : ST_D;
      ST_D:    return i ? ST_B : ST_A;
      default: return ST_B;
    endcase
  endfunction

  function automatic logic tbl_out(st_e s, logic i);
    case (s)
      ST_A:    return 1'b1;
      ST_B:    return i;
      ST_D:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] seg_last(seg_e k);
    case (k)
      SG_SYNC: return OFF_W'(3);
      SG_DIST: return OFF_W'(2);
      SG_D2E:  return OFF_W'(2);
      default: return OFF_W'(0);
    endcase
  endfunction

  function automatic logic seg_bit(seg_e k, logic [OFF_W-1:0] off);
    case (k)
      SG_DIST: return off != OFF_W'(2);
      SG_ONE:  return 1'b1;
      SG_D2E:  return off != OFF_W'(0);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/chkseq_rom.sv
module chkseq_rom
  import chkseq_pkg::*;
(
  input  logic [SEG_W-1:0] idx_i,
  output seg_e             kind_o
);
  always_comb begin
    case (idx_i)
      6'd0:                             kind_o = SG_SYNC;
      6'd4, 6'd6:                       kind_o = SG_ONE;
      6'd8, 6'd10, 6'd12:               kind_o = SG_ZERO;
      6'd14, 6'd16, 6'd19, 6'd25:       kind_o = SG_ONE;
      6'd22, 6'd28:                     kind_o = SG_ZERO;
      6'd27, 6'd30:                     kind_o = SG_D2E;
      6'd31:                            kind_o = SG_ONE;
      default:                          kind_o = SG_DIST;
    endcase
  end
endmodule

// File: rtl/chkseq_sequencer.sv
module chkseq_sequencer
  import chkseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              last_o,
  output logic              sync_o,
  output logic              stim_o,
  output logic [STEP_W-1:0] step_o
);
  logic              busy_q;
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic [STEP_W-1:0] step_q;
  seg_e              kind;
  logic              seg_end;

  chkseq_rom u_rom (.idx_i(seg_q), .kind_o(kind));

  assign seg_end  = off_q == seg_last(kind);
  assign accept_o = start_i && !busy_q;
  assign last_o   = busy_q && seg_end && (seg_q == SEG_W'(SEG_CNT - 1));
  assign sync_o   = busy_q && (kind == SG_SYNC);
  assign stim_o   = busy_q && seg_bit(kind, off_q);
  assign busy_o   = busy_q;
  assign step_o   = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      seg_q  <= '0;
      off_q  <= '0;
      step_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      seg_q  <= '0;
      off_q  <= '0;
      step_q <= '0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
        seg_q  <= '0;
        off_q  <= '0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
        if (seg_end) begin
          seg_q <= seg_q + 1'b1;
          off_q <= '0;
        end else begin
          off_q <= off_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chkseq_ref.sv
module chkseq_ref
  import chkseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic sync_i,
  input  logic stim_i,
  output logic exp_o
);
  st_e st_q;

  assign exp_o = tbl_out(st_q, stim_i);

  // held at A through the prefix, then tracks the table
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= ST_A;
    else if (sync_i)  st_q <= ST_A;
    else if (busy_i)  st_q <= tbl_next(st_q, stim_i);
  end
endmodule

// File: rtl/chkseq_verdict.sv
module chkseq_verdict
  import chkseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic              sync_i,
  input  logic              last_i,
  input  logic              exp_i,
  input  logic              resp_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              pass_o,
  output logic              fail_o,
  output logic [STEP_W-1:0] fail_step_o
);
  logic miss;

  assign miss = busy_i && !sync_i && (resp_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      fail_step_o <= '0;
    end else if (accept_i) begin
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      fail_step_o <= '0;
    end else begin
      if (miss && !fail_o) begin
        fail_o      <= 1'b1;
        fail_step_o <= step_i;
      end
      if (last_i) pass_o <= !(fail_o || miss);
    end
  end
endmodule

// File: rtl/mealy_check_seq.sv
module mealy_check_seq
  import chkseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              resp_i,
  output logic              stim_o,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [STEP_W-1:0] fail_step_o
);
  logic              accept_w;
  logic              last_w;
  logic              sync_w;
  logic              exp_w;
  logic [STEP_W-1:0] step_w;

  chkseq_sequencer u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .accept_o (accept_w),
    .last_o   (last_w),
    .sync_o   (sync_w),
    .stim_o   (stim_o),
    .step_o   (step_w)
  );

  chkseq_ref u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_o),
    .sync_i (sync_w),
    .stim_i (stim_o),
    .exp_o  (exp_w)
  );

  chkseq_verdict u_vrd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept_w),
    .busy_i      (busy_o),
    .sync_i      (sync_w),
    .last_i      (last_w),
    .exp_i       (exp_w),
    .resp_i      (resp_i),
    .step_i      (step_w),
    .pass_o      (pass_o),
    .fail_o      (fail_o),
    .fail_step_o (fail_step_o)
  );
endmodule

// File: rtl/chkseq_checker.sv
module chkseq_checker
  import chkseq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stim_o,
  input logic              busy_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [STEP_W-1:0] fail_step_o,
  input logic              sync_w,
  input logic [STEP_W-1:0] step_w
);
  a_r2_idle_stim_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !stim_o);

  a_r3_sync_drives_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_w |-> !stim_o);

  a_r3_no_fail_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_w && !fail_o) |=> !fail_o);

  a_r7_first_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !(start_i && !busy_o)) |=> (fail_o && $stable(fail_step_o)));

  a_r8_verdict_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  a_r8_verdict_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (pass_o != fail_o));

  a_r9_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && step_w != STEP_W'(SEQ_LEN - 1)) |=> (busy_o && step_w == $past(step_w) + 1'b1));

  a_r10_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!pass_o && !fail_o && busy_o));
endmodule

bind mealy_check_seq chkseq_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stim_o      (stim_o),
  .busy_o      (busy_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .fail_step_o (fail_step_o),
  .sync_w      (sync_w),
  .step_w      (step_w)
);

// File: tb/mealy_check_seq_bench.sv
`timescale 1ns/1ps
module mealy_check_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       resp;
  logic       stim;
  logic       busy, pass, fail;
  logic [6:0] fstep;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit ended = 0;

  // bench copy of the machine under test: states 0..4 = A..E
  int dut_st = 0;
  int fault = 0;
  bit inv_now = 0;
  int seq_q[$];

  always #2 clk = ~clk;

  function automatic int g_next(int s, int i);
    case (s)
      0: return i ? 2 : 0;
      1: return i ? 0 : 2;
      2: return i ? 4 : 3;
      3: return i ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  function automatic int g_out(int s, int i);
    case (s)
      0: return 1;
      1: return i;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int m_next(int s, int i, int f);
    if (f == 2 && s == 3 && i == 1) return 0;
    return g_next(s, i);
  endfunction

  function automatic int m_out(int s, int i, int f);
    int o;
    o = g_out(s, i);
    if (f == 1 && s == 4 && i == 1) o = 1 - o;
    if (f == 4 && s == 2 && i == 0) o = 1 - o;
    if (f == 5 && s == 0 && i == 0) o = 1 - o;
    return o;
  endfunction

  assign resp = (m_out(dut_st, int'(stim), fault) != 0) ^ inv_now;

  always @(posedge clk) dut_st <= m_next(dut_st, int'(stim), fault);

  mealy_check_seq u_mealy_check_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .resp_i(resp),
    .stim_o(stim), .busy_o(busy), .pass_o(pass), .fail_o(fail), .fail_step_o(fstep)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic build_seq();
    string segs[$] = '{"0000",
      "110","110","110","1","110","1","110",
      "0","110","0","110","0","110","1","110","1","110",
      "110","1","110","110","0","110","110","1","110",
      "011","0","110","011","1","110"};
    foreach (segs[j])
      for (int c = 0; c < segs[j].len(); c++) seq_q.push_back(segs[j][c] == "1" ? 1 : 0);
  endtask

  // one run; poke: pulse start mid-run; inv_sync: invert responses in the prefix
  task automatic run(int f, int init, bit poke, bit inv_sync, string req);
    int gst = 0;
    int exp_fs = -1;
    int n_stim_bad = 0;
    @(negedge clk);
    fault = f;
    dut_st = init;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!pass && !fail && fstep == 0, "R10 verdict cleared on start", int'(pass) + int'(fail), 0);
    for (int k = 0; k < 76; k++) begin
      inv_now = inv_sync && (k < 4);
      #0.1;
      if (!busy || int'(stim) != seq_q[k]) n_stim_bad++;
      if (k >= 4 && exp_fs < 0 && int'(resp) != g_out(gst, int'(stim))) exp_fs = k;
      gst = (k < 4) ? 0 : g_next(gst, int'(stim));
      if (poke && k == 30) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (k > 4 && exp_fs >= 0 && exp_fs < k)
        if (!fail || int'(fstep) != exp_fs) n_stim_bad++;
    end
    inv_now = 0;
    chk(n_stim_bad == 0, {req, " R2 R4 R5 stream/busy per step"}, n_stim_bad, 0);
    chk(!busy, "R2 busy drops after 76 cycles", int'(busy), 0);
    chk(pass == (exp_fs < 0), {req, " R8 pass"}, int'(pass), int'(exp_fs < 0));
    chk(fail == (exp_fs >= 0), {req, " R6 R7 fail"}, int'(fail), int'(exp_fs >= 0));
    if (exp_fs >= 0) chk(int'(fstep) == exp_fs, {req, " R7 first step"}, int'(fstep), exp_fs);
    repeat (5) @(negedge clk);
    chk(pass == (exp_fs < 0) && !busy && !stim, "R8 verdict held idle", int'(pass), int'(exp_fs < 0));
  endtask

  initial begin
    build_seq();
    #1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !pass && !fail && fstep == 0 && !stim, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !stim, "R1 idle after reset", int'(stim), 0);
    for (int s = 0; s < 5; s++) run(0, s, 0, 0, "R3 R4 clean start");
    run(0, 4, 0, 1, "R3 prefix masked");
    run(1, 0, 0, 0, "R6 out flip E1");
    run(2, 1, 0, 0, "R5 next flip D1");
    run(4, 2, 0, 0, "R6 out flip C0");
    run(5, 3, 1, 0, "R9 poke busy with A0 flip");
    run(0, 0, 1, 0, "R9 poke busy clean");
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      ended = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule